// File: doc/BRIEF.md
# Bit-String Bit Manipulator

This unit sets, clears or tests a single bit inside a long bit string that lives in byte-wide memory. Two 16-bit pointer values locate the bit. The base pointer holds the address of the string's first byte, which may be anywhere in a 64K-byte space. The index pointer gives the byte offset within the string in its upper 13 bits, so a string can be up to 8K bytes (64K bits) long. The lowest 3 bits of the index pointer select the bit inside that byte.

A caller presents an operation code and both pointers together with a one-cycle start strobe. The unit then reads the addressed byte over a simple synchronous memory port. For set and clear it writes the byte back with only the selected bit changed. For a test it leaves memory alone and raises a skip flag when the bit is clear, so a sequencer can skip its next step. Every access is one byte wide, and a one-cycle done pulse marks the end of each operation.

Top module: `bitstr_bitop`

## Requirements
- R1: The byte address is basePtr plus (indexPtr shifted right by 3), taken modulo 2^16. It is driven on memAddr during a one-cycle read (memRd high), and any write-back goes to the same address.
- R2: indexPtr[2:0] selects the bit, with 0 being the least significant bit of the byte.
- R3: opCode 2'b00 (set) performs exactly one read and then one write in the very next cycle. The written byte equals the byte read with the selected bit forced to 1.
- R4: opCode 2'b01 (clear) performs the same read-then-write, with the selected bit forced to 0 and every other bit kept as read.
- R5: opCode 2'b10 and 2'b11 (test) perform exactly one read and no write. skipFlag becomes 1 if the selected bit was 0 and becomes 0 if it was 1.
- R6: The memory read data is returned one cycle after memRd. For every operation, done is a one-cycle pulse that appears in the third cycle after the clock edge that samples start. busy is high from the cycle after that edge through the done cycle.
- R7: A start strobe raised while busy is high is ignored. No extra memory access happens.
- R8: skipFlag is cleared when a start is accepted. Only a completed test changes it, and it then holds its value until the next accepted start.
- R9: While reset is held (rstN low), busy, done, memRd, memWr and skipFlag are all 0.
- R10: The operation code and both pointers are captured at the accepted start. Changing them during the operation has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| opCode | input | 2 | 00 set, 01 clear, 1x test |
| basePtr | input | 16 | Address of the string's first byte |
| indexPtr | input | 16 | Byte offset in [15:3], bit number in [2:0] |
| memAddr | output | 16 | Memory byte address |
| memRd | output | 1 | Read strobe; data returned the next cycle |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| skipFlag | output | 1 | Tested bit was clear |

## Verification
The assertions assume that the memory returns read data exactly one cycle after memRd and keeps that data on memRdata during the write cycle that follows. The bench memory model registers its read data on the read edge and changes it only on a later read, which keeps that assumption true. The assertions also assume that the byte written back differs from the byte read in at most one bit. They make no assumption about start timing. The bench deliberately raises start while the unit is busy, and it changes the pointers in the middle of an operation.

// File: rtl/bitstr_pkg.sv
package bitstr_pkg;
  // Strobes from control to datapath for one operation.
  typedef struct packed {
    logic latchOp;   // capture operands, clear skip flag
    logic doRead;    // issue memory read
    logic doWrite;   // issue write-back of modified byte
    logic capture;   // sample tested bit
  } ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_MOD  = 2'd2,
    ST_FIN  = 2'd3
  } state_t;
endpackage

// File: rtl/bitstr_ctrl.sv
module bitstr_ctrl
  import bitstr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic isTest,
  output ctl_t ctl,
  output logic busy,
  output logic done
);
  state_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.latchOp = 1'b1;
        stateNxt    = ST_READ;
      end
      ST_READ: begin
        ctl.doRead = 1'b1;
        stateNxt   = ST_MOD;
      end
      ST_MOD: begin
        ctl.doWrite = !isTest;
        ctl.capture = isTest;
        stateNxt    = ST_FIN;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.doRead && ctl.doWrite)); // R3
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doWrite |-> $past(ctl.doRead)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !ctl.latchOp); // R7
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !ctl.doWrite); // R5
endmodule

// File: rtl/bitstr_dpath.sv
module bitstr_dpath
  import bitstr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int SEL_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [1:0]        opCode,
  input  logic [ADDR_W-1:0] basePtr,
  input  logic [ADDR_W-1:0] indexPtr,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              isTest,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              skipFlag
);
  logic [ADDR_W-1:0] addrReg;
  logic [SEL_W-1:0]  selReg;
  logic [1:0]        opReg;
  logic [BYTE_W-1:0] bitMask;
  logic [ADDR_W-1:0] byteOff;

  assign byteOff = indexPtr >> SEL_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      selReg  <= '0;
      opReg   <= '0;
    end else if (ctl.latchOp) begin
      addrReg <= basePtr + byteOff;
      selReg  <= indexPtr[SEL_W-1:0];
      opReg   <= opCode;
    end
  end

  // one-hot bit mask
  for (genvar g = 0; g < BYTE_W; g++) begin : g_mask
    assign bitMask[g] = (selReg == SEL_W'(g));
  end

  assign isTest   = opReg[1];
  assign memAddr  = addrReg;
  assign memWdata = opReg[0] ? (memRdata & ~bitMask) : (memRdata | bitMask);

  always_ff @(posedge clk) begin
    if (!rstN)            skipFlag <= 1'b0;
    else if (ctl.latchOp) skipFlag <= 1'b0;
    else if (ctl.capture) skipFlag <= ~|(memRdata & bitMask);
  end

  AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doWrite |-> ($countones(memWdata ^ memRdata) <= 1)); // R2
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doWrite |-> $stable(memAddr)); // R1
  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.latchOp && !ctl.capture) |=> $stable(skipFlag)); // R8
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bitMask)); // R2
endmodule

// File: rtl/bitstr_bitop.sv
module bitstr_bitop
  import bitstr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  opCode,
  input  logic [15:0] basePtr,
  input  logic [15:0] indexPtr,
  output logic [15:0] memAddr,
  output logic        memRd,
  output logic        memWr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        busy,
  output logic        done,
  output logic        skipFlag
);
  ctl_t ctl;
  logic isTest;

  bitstr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .isTest(isTest),
    .ctl(ctl), .busy(busy), .done(done)
  );

  bitstr_dpath #(.ADDR_W(16), .BYTE_W(8)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opCode(opCode),
    .basePtr(basePtr), .indexPtr(indexPtr), .memRdata(memRdata),
    .isTest(isTest), .memAddr(memAddr), .memWdata(memWdata),
    .skipFlag(skipFlag)
  );

  assign memRd = ctl.doRead;
  assign memWr = ctl.doWrite;
endmodule

// File: tb/bitstr_bitop_tb_top.sv
module bitstr_bitop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opCode = '0;
  logic [15:0] basePtr = '0, indexPtr = '0;
  logic [15:0] memAddr;
  logic        memRd, memWr, busy, done, skipFlag;
  logic [7:0]  memWdata, memRdata;

  always #4 clk = ~clk;

  bitstr_bitop dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .basePtr(basePtr), .indexPtr(indexPtr), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .skipFlag(skipFlag)
  );

  // 256-byte memory model indexed by low address byte
  logic [7:0]  mem [0:255];
  logic        preEn = 1'b0;
  logic [7:0]  preAddr = '0, preData = '0;
  int          rdCnt = 0, wrCnt = 0;
  logic [15:0] rdAddrSeen = '0, wrAddrSeen = '0;

  always @(posedge clk) begin
    if (preEn) mem[preAddr] <= preData;
    if (memRd) begin
      memRdata   <= mem[memAddr[7:0]];
      rdCnt      <= rdCnt + 1;
      rdAddrSeen <= memAddr;
    end
    if (memWr) begin
      mem[memAddr[7:0]] <= memWdata;
      wrCnt      <= wrCnt + 1;
      wrAddrSeen <= memAddr;
    end
  end

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] base;
    logic [15:0] idx;
    logic [7:0]  init;
    logic [15:0] addr;
    logic [7:0]  fin;
    logic        skip;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h1000, 16'h0005, 8'h00, 16'h1000, 8'h20, 1'b0},
    '{2'd1, 16'h2000, 16'h0013, 8'hFF, 16'h2002, 8'hF7, 1'b0},
    '{2'd2, 16'h3000, 16'h0027, 8'h80, 16'h3004, 8'h80, 1'b0},
    '{2'd2, 16'h3000, 16'h0026, 8'h80, 16'h3004, 8'h80, 1'b1},
    '{2'd0, 16'hFFF0, 16'hFFFF, 8'h01, 16'h1FEF, 8'h81, 1'b0},
    '{2'd1, 16'h00FF, 16'h0008, 8'h55, 16'h0100, 8'h54, 1'b0},
    '{2'd0, 16'h4000, 16'h0002, 8'h04, 16'h4000, 8'h04, 1'b0},
    '{2'd3, 16'h0010, 16'h0039, 8'hFD, 16'h0017, 8'hFD, 1'b1},
    '{2'd1, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h00, 1'b0}
  };

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    preEn = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preEn = 1'b0;
  endtask

  // Issue start, return number of cycles until done is seen.
  task automatic runOp(input logic [1:0] op, input logic [15:0] b, input logic [15:0] x, output int lat);
    @(negedge clk);
    start = 1'b1; opCode = op; basePtr = b; indexPtr = x;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat, r0, w0;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRd && !memWr && !skipFlag, "R9 reset outputs",
          {busy, done, memRd, memWr, skipFlag}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      preload(VECS[i].addr[7:0], VECS[i].init);
      r0 = rdCnt; w0 = wrCnt;
      runOp(VECS[i].op, VECS[i].base, VECS[i].idx, lat);
      check(lat == 3, "R6 done latency", lat, 3);
      @(negedge clk);
      check(!done && !busy, "R6 done one cycle", {done, busy}, 0);
      check(rdCnt - r0 == 1, "R1 one read", rdCnt - r0, 1);
      check(rdAddrSeen == VECS[i].addr, "R1 address", rdAddrSeen, VECS[i].addr);
      if (VECS[i].op[1]) begin
        check(wrCnt == w0, "R5 test no write", wrCnt - w0, 0);
        check(skipFlag == VECS[i].skip, "R5 skip flag", skipFlag, VECS[i].skip);
      end else begin
        check(wrCnt - w0 == 1, "R3 one write", wrCnt - w0, 1);
        check(wrAddrSeen == VECS[i].addr, "R1 write address", wrAddrSeen, VECS[i].addr);
        check(skipFlag == 1'b0, "R8 skip clear after set/clear", skipFlag, 0);
      end
      check(mem[VECS[i].addr[7:0]] == VECS[i].fin,
            VECS[i].op == 2'd1 ? "R4 byte" : "R2 R3 byte",
            mem[VECS[i].addr[7:0]], VECS[i].fin);
    end

    // R8: skip flag holds, then cleared by next accepted start
    preload(8'h40, 8'h00);
    runOp(2'd2, 16'h0040, 16'h0003, lat);
    repeat (5) @(negedge clk);
    check(skipFlag == 1'b1, "R8 skip held", skipFlag, 1);
    @(negedge clk);
    start = 1'b1; opCode = 2'd0; basePtr = 16'h0040; indexPtr = 16'h0003;
    @(negedge clk);
    start = 1'b0;
    check(skipFlag == 1'b0, "R8 skip cleared on start", skipFlag, 1'b0);
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    repeat (4) @(negedge clk);

    // R7/R10: start while busy ignored, operand changes ignored
    preload(8'h50, 8'hF0);
    preload(8'h60, 8'hAA);
    r0 = rdCnt; w0 = wrCnt;
    @(negedge clk);
    start = 1'b1; opCode = 2'd0; basePtr = 16'h0050; indexPtr = 16'h0001;
    @(negedge clk);
    start = 1'b1; opCode = 2'd1; basePtr = 16'h0060; indexPtr = 16'h000F;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(rdCnt - r0 == 1, "R7 single read", rdCnt - r0, 1);
    check(wrCnt - w0 == 1, "R7 single write", wrCnt - w0, 1);
    check(mem[8'h50] == 8'hF2, "R10 latched operands", mem[8'h50], 8'hF2);
    check(mem[8'h60] == 8'hAA, "R7 other byte untouched", mem[8'h60], 8'hAA);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule